// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a free-running timer built from two stacked counters. A prescale counter steps on every clock and, when it reaches a programmable prescale value, wraps to zero and advances a 32-bit timer count. The timer count is compared against a bank of seven match values. Each match value has its own group of three action bits. These bits can latch an interrupt flag, return the timer count to zero, or halt counting by clearing the run bit.

Software reaches every register through a simple word-addressed register port with address, write data, write enable and a combinational read. The block drives two kinds of output. One is a one-cycle strobe per match value, meant for downstream waveform logic. The other is a single interrupt line that is the OR of all pending flags. Pending flags are cleared by writing ones to them.

Top module: `prescaled_match_timer`

## Requirements
- R1: After reset every register reads 0, `match_o` is 0 and `irq_o` is 0.
- R2: While running, the prescale counter (address 4) steps by one per clock. In a clock where it is greater than or equal to the prescale value (address 3), it returns to 0 and the timer count (address 2) steps by one. The timer count therefore advances once every prescale+1 clocks. A prescale counter left above the prescale value wraps on the very next running clock.
- R3: While control bit 1 (counter clear) is set, the timer count and prescale counter are held at 0 whatever bit 0 says, and no match events occur.
- R4: While control bit 0 (run) is clear and bit 1 is clear, the timer count and prescale counter keep their values.
- R5: `match_o[i]` is high for exactly one clock: the running clock in which the prescale counter wraps while the timer count equals match value i (address 8+i).
- R6: When the event of R5 occurs and action bit 3i is set, pending flag i (bit i of address 0) is set at the next edge. `irq_o` is high whenever any pending flag is set.
- R7: Writing address 0 clears each pending flag whose write-data bit is 1 and leaves flags whose bit is 0. A flag being set in the same clock as its clear stays set.
- R8: When the event of R5 occurs and action bit 3i+1 is set, the timer count becomes 0 at that edge instead of match value i plus one.
- R9: When the event of R5 occurs and action bit 3i+2 is set, control bit 0 clears at that edge, the prescale counter becomes 0, and the timer count keeps match value i. If bit 3i+1 is also set, the timer count becomes 0.
- R10: Register map: 0 pending flags, 1 control, 2 timer count, 3 prescale value, 4 prescale counter, 5 action bits, 8+i match value i. Writes to 1, 3, 5 and 8+i store the value. Writes to 2 and 4 load the counters. Unmapped addresses read 0.
- R11: A match value whose three action bits are 0 still strobes `match_o` but sets no flag, does not reset the count and does not halt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Register word address |
| bus_wdata | input | DATA_W (32) | Register write data |
| bus_we | input | 1 | Register write enable, one write per clock |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| match_o | output | N_MATCH (7) | Per-match one-clock event strobes |
| irq_o | output | 1 | OR of all pending flags |

## Verification
The bench times the match strobe against a prescale of two, where the timer count dwells on a value for three clocks. A design that compared on every clock of the dwell would raise the strobe for three clocks instead of one. It also puts a flag clear on the same edge as a new event on that flag; a design that let the clear win would lose the interrupt. Halting is checked with the reset action on and with it off. A design that let the counter step past the match value, or that ignored the reset action on halt, would leave the wrong timer count behind. A prescale counter loaded above the prescale value is also checked; a design that compared for equality would run on for about four billion clocks before its next tick.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
   // word addresses of the register port
   localparam int unsigned REG_IRQ      = 0;
   localparam int unsigned REG_CTRL     = 1;
   localparam int unsigned REG_COUNT    = 2;
   localparam int unsigned REG_PRESCALE = 3;
   localparam int unsigned REG_PCOUNT   = 4;
   localparam int unsigned REG_ACTION   = 5;
   localparam int unsigned REG_MATCH0   = 8;

   // control register bits
   localparam int unsigned CTRL_RUN_BIT = 0;
   localparam int unsigned CTRL_CLR_BIT = 1;
   localparam int unsigned CTRL_W       = 2;

   // per-match action group: bit 0 flag, bit 1 wrap, bit 2 halt
   localparam int unsigned ACT_W = 3;
   typedef struct packed {
      logic halt;
      logic wrap;
      logic flag;
   } match_act_t;
endpackage

// File: rtl/ptm_prescaler.sv
module ptm_prescaler #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         hold_zero,
   input  logic         halt,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] limit,
   output logic [W-1:0] count,
   output logic         tick
);
   // greater-or-equal so a counter left above the limit wraps at once
   assign tick = run && (count >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             count <= '0;
      else if (hold_zero)     count <= '0;
      else if (load)          count <= load_val;
      else if (halt || tick)  count <= '0;
      else if (run)           count <= count + W'(1);
   end
endmodule

// File: rtl/ptm_counter.sv
module ptm_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         hold_zero,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         wrap,
   input  logic         halt,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          count <= '0;
      else if (hold_zero)  count <= '0;
      else if (load)       count <= load_val;
      else if (wrap)       count <= '0;
      else if (halt)       count <= count;
      else if (tick)       count <= count + W'(1);
   end
endmodule

// File: rtl/ptm_match_bank.sv
module ptm_match_bank
   import ptm_pkg::*;
#(
   parameter int unsigned W = 32,
   parameter int unsigned N = 7
) (
   input  logic [W-1:0]     count,
   input  logic             tick,
   input  logic [N*W-1:0]   values,
   input  logic [N*ACT_W-1:0] actions,
   output logic [N-1:0]     hit,
   output logic [N-1:0]     flag_set,
   output logic             wrap,
   output logic             halt
);
   logic [N-1:0] wrap_v;
   logic [N-1:0] halt_v;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      match_act_t act;
      assign act         = match_act_t'(actions[i*ACT_W +: ACT_W]);
      assign hit[i]      = tick && (count == values[i*W +: W]);
      assign flag_set[i] = hit[i] && act.flag;
      assign wrap_v[i]   = hit[i] && act.wrap;
      assign halt_v[i]   = hit[i] && act.halt;
   end

   assign wrap = |wrap_v;
   assign halt = |halt_v;
endmodule

// File: rtl/ptm_irq_flags.sv
module ptm_irq_flags #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr_en,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] flags,
   output logic         irq
);
   logic [N-1:0] clr_v;
   assign clr_v = clr_en ? clr_mask : '0;

   // a set in the clearing cycle survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_v) | set;
   end

   assign irq = |flags;
endmodule

// File: rtl/ptm_regfile.sv
module ptm_regfile
   import ptm_pkg::*;
#(
   parameter int unsigned W  = 32,
   parameter int unsigned N  = 7,
   parameter int unsigned AW = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [AW-1:0]      addr,
   input  logic [W-1:0]       wdata,
   input  logic               halt_hit,
   output logic [CTRL_W-1:0]  ctrl,
   output logic [W-1:0]       prescale,
   output logic [N*ACT_W-1:0] actions,
   output logic [N*W-1:0]     values
);
   logic wr_ctrl, wr_pre, wr_act;
   assign wr_ctrl = we && (addr == AW'(REG_CTRL));
   assign wr_pre  = we && (addr == AW'(REG_PRESCALE));
   assign wr_act  = we && (addr == AW'(REG_ACTION));

   // software write beats the halt action in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctrl <= '0;
      else if (wr_ctrl)  ctrl <= wdata[CTRL_W-1:0];
      else if (halt_hit) ctrl[CTRL_RUN_BIT] <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prescale <= '0;
      else if (wr_pre) prescale <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      actions <= '0;
      else if (wr_act) actions <= wdata[N*ACT_W-1:0];
   end

   for (genvar i = 0; i < N; i++) begin : g_val
      logic [W-1:0] val_q;
      logic         wr_val;
      assign wr_val = we && (addr == AW'(REG_MATCH0 + i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      val_q <= '0;
         else if (wr_val) val_q <= wdata;
      end
      assign values[i*W +: W] = val_q;
   end
endmodule

// File: rtl/prescaled_match_timer.sv
module prescaled_match_timer
   import ptm_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned N_MATCH = 7,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic               bus_we,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [N_MATCH-1:0] match_o,
   output logic               irq_o
);
   localparam int unsigned ACT_BITS  = N_MATCH * ACT_W;
   localparam int unsigned ADDR_SPAN = 2 ** ADDR_W;

   // elaboration-time parameter checks
   if (N_MATCH < 1) begin : g_bad_n
      $error("N_MATCH must be at least 1");
   end
   if (ACT_BITS > DATA_W) begin : g_bad_act
      $error("action bits do not fit in one data word");
   end
   if (REG_MATCH0 + N_MATCH > ADDR_SPAN) begin : g_bad_addr
      $error("ADDR_W too small for the match registers");
   end
   if (DATA_W < CTRL_W) begin : g_bad_w
      $error("DATA_W too small for the control register");
   end

   logic [CTRL_W-1:0]   ctrl_q;
   logic [DATA_W-1:0]   pre_q;
   logic [ACT_BITS-1:0] act_q;
   logic [N_MATCH*DATA_W-1:0] val_q;
   logic [DATA_W-1:0]   tc_q, pc_q;
   logic [N_MATCH-1:0]  hit, flag_set, flags_q;
   logic run, clr, tick, wrap_hit, halt_hit;
   logic load_tc, load_pc, clr_flags;

   assign clr       = ctrl_q[CTRL_CLR_BIT];
   assign run       = ctrl_q[CTRL_RUN_BIT] && !clr;
   assign load_tc   = bus_we && (bus_addr == ADDR_W'(REG_COUNT));
   assign load_pc   = bus_we && (bus_addr == ADDR_W'(REG_PCOUNT));
   assign clr_flags = bus_we && (bus_addr == ADDR_W'(REG_IRQ));

   ptm_regfile #(.W(DATA_W), .N(N_MATCH), .AW(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bus_we),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .halt_hit (halt_hit),
      .ctrl     (ctrl_q),
      .prescale (pre_q),
      .actions  (act_q),
      .values   (val_q)
   );

   ptm_prescaler #(.W(DATA_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .hold_zero (clr),
      .halt      (halt_hit),
      .load      (load_pc),
      .load_val  (bus_wdata),
      .limit     (pre_q),
      .count     (pc_q),
      .tick      (tick)
   );

   ptm_counter #(.W(DATA_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .hold_zero (clr),
      .load      (load_tc),
      .load_val  (bus_wdata),
      .wrap      (wrap_hit),
      .halt      (halt_hit),
      .count     (tc_q)
   );

   ptm_match_bank #(.W(DATA_W), .N(N_MATCH)) u_match (
      .count    (tc_q),
      .tick     (tick),
      .values   (val_q),
      .actions  (act_q),
      .hit      (hit),
      .flag_set (flag_set),
      .wrap     (wrap_hit),
      .halt     (halt_hit)
   );

   ptm_irq_flags #(.N(N_MATCH)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (flag_set),
      .clr_en   (clr_flags),
      .clr_mask (bus_wdata[N_MATCH-1:0]),
      .flags    (flags_q),
      .irq      (irq_o)
   );

   assign match_o = hit;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(REG_IRQ))      bus_rdata[N_MATCH-1:0]  = flags_q;
      if (bus_addr == ADDR_W'(REG_CTRL))     bus_rdata[CTRL_W-1:0]   = ctrl_q;
      if (bus_addr == ADDR_W'(REG_COUNT))    bus_rdata               = tc_q;
      if (bus_addr == ADDR_W'(REG_PRESCALE)) bus_rdata               = pre_q;
      if (bus_addr == ADDR_W'(REG_PCOUNT))   bus_rdata               = pc_q;
      if (bus_addr == ADDR_W'(REG_ACTION))   bus_rdata[ACT_BITS-1:0] = act_q;
      for (int i = 0; i < int'(N_MATCH); i++) begin
         if (bus_addr == ADDR_W'(REG_MATCH0 + i)) bus_rdata = val_q[i*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/prescaled_match_timer_chk.sv
module prescaled_match_timer_chk
   import ptm_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned N_MATCH = 7,
   parameter int unsigned ADDR_W  = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic                       bus_we,
   input logic [N_MATCH-1:0]         match_o,
   input logic                       irq_o,
   input logic [DATA_W-1:0]          tc,
   input logic [DATA_W-1:0]          pc,
   input logic [CTRL_W-1:0]          ctrl,
   input logic [N_MATCH*ACT_W-1:0]   mctl
);
   logic [N_MATCH-1:0] flag_m, wrap_m, halt_m;
   for (genvar g = 0; g < N_MATCH; g++) begin : g_mask
      match_act_t a;
      assign a         = match_act_t'(mctl[g*ACT_W +: ACT_W]);
      assign flag_m[g] = a.flag;
      assign wrap_m[g] = a.wrap;
      assign halt_m[g] = a.halt;
   end

   logic wr_ctrl, wr_tc;
   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(REG_CTRL));
   assign wr_tc   = bus_we && (bus_addr == ADDR_W'(REG_COUNT));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_tc |=> (tc == $past(tc) || tc == $past(tc) + DATA_W'(1) || tc == '0));

   assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[CTRL_CLR_BIT] |=> (tc == '0 && pc == '0));

   assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[CTRL_RUN_BIT] && !ctrl[CTRL_CLR_BIT] && !bus_we) |=> ($stable(tc) && $stable(pc)));

   assert_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o != '0) |-> (ctrl[CTRL_RUN_BIT] && !ctrl[CTRL_CLR_BIT]));

   assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((match_o & flag_m) != '0) |=> irq_o);

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !bus_we) |=> irq_o);

   assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (((match_o & wrap_m) != '0) && !wr_tc) |=> (tc == '0));

   assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (((match_o & halt_m) != '0) && !wr_ctrl) |=> !ctrl[CTRL_RUN_BIT]);
endmodule

bind prescaled_match_timer prescaled_match_timer_chk #(
   .DATA_W(DATA_W), .N_MATCH(N_MATCH), .ADDR_W(ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_we   (bus_we),
   .match_o  (match_o),
   .irq_o    (irq_o),
   .tc       (tc_q),
   .pc       (pc_q),
   .ctrl     (ctrl_q),
   .mctl     (act_q)
);

// File: tb/sim_prescaled_match_timer.sv
module sim_prescaled_match_timer;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int W  = 32;
   localparam int N  = 7;
   localparam int AW = 4;

   localparam logic [AW-1:0] A_IRQ = 0, A_CTRL = 1, A_TC = 2, A_PR = 3, A_PC = 4, A_ACT = 5, A_GAP = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [W-1:0]  bus_wdata = '0;
   logic          bus_we = 1'b0;
   logic [W-1:0]  bus_rdata;
   logic [N-1:0]  match_o;
   logic          irq_o;

   always #2.5 clk = ~clk;

   prescaled_match_timer #(.DATA_W(W), .N_MATCH(N), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .match_o(match_o), .irq_o(irq_o)
   );

   // scoreboard: kind 0 = read data, 1 = match strobes, 2 = interrupt line
   typedef struct {
      int          kind;
      logic [W-1:0] exp;
      string       req;
   } item_t;

   item_t sb[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   initial begin
      item_t it;
      logic [W-1:0] act;
      forever begin
         wait (sb.size() != 0);
         it = sb.pop_front();
         case (it.kind)
            0:       act = bus_rdata;
            1:       act = W'(match_o);
            default: act = W'(irq_o);
         endcase
         checks++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s kind=%0d addr=%0d: actual=%h expected=%h", it.req, it.kind, bus_addr, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic expect_reg(input logic [AW-1:0] a, input logic [W-1:0] e, input string req);
      item_t it;
      @(negedge clk);
      bus_addr = a;
      #1;
      it.kind = 0; it.exp = e; it.req = req;
      sb.push_back(it);
      #0.5;
   endtask

   task automatic expect_pins(input logic [N-1:0] m, input logic q, input string req);
      item_t it;
      @(negedge clk);
      #1;
      it.kind = 1; it.exp = W'(m); it.req = req;
      sb.push_back(it);
      it.kind = 2; it.exp = W'(q);
      sb.push_back(it);
      #0.5;
   endtask

   // enable, let exactly n edges count, then disable
   task automatic run_for(input int n);
      wr(A_CTRL, 32'd1);
      repeat (n - 1) @(negedge clk);
      wr(A_CTRL, 32'd0);
   endtask

   task automatic zero_counters();
      wr(A_TC, 32'd0);
      wr(A_PC, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 16; a++) expect_reg(AW'(a), '0, "R1");
      expect_pins('0, 1'b0, "R1");

      // R10: store, load and read back
      wr(A_PR, 32'd3);
      expect_reg(A_PR, 32'd3, "R10");
      wr(AW'(8), 32'd5);
      expect_reg(AW'(8), 32'd5, "R10");
      wr(A_ACT, 32'h0012_3456);
      expect_reg(A_ACT, 32'h0012_3456 & 32'h001F_FFFF, "R10");
      wr(A_TC, 32'd7);
      expect_reg(A_TC, 32'd7, "R10");
      wr(A_PC, 32'd2);
      expect_reg(A_PC, 32'd2, "R10");
      expect_reg(A_GAP, '0, "R10");

      // R4: stopped counters keep their values
      repeat (10) @(negedge clk);
      expect_reg(A_TC, 32'd7, "R4");
      expect_reg(A_PC, 32'd2, "R4");

      // R3: clear bit holds zero and suppresses matches
      wr(AW'(8), 32'd0);
      wr(A_ACT, 32'd1);
      wr(A_CTRL, 32'd3);
      repeat (10) @(negedge clk);
      expect_reg(A_TC, 32'd0, "R3");
      expect_reg(A_PC, 32'd0, "R3");
      expect_reg(A_IRQ, 32'd0, "R3");
      expect_reg(A_CTRL, 32'd3, "R3");
      expect_pins('0, 1'b0, "R3");
      wr(A_CTRL, 32'd0);
      wr(A_ACT, 32'd0);

      // R2: prescale of 3, ten counting edges -> count 2, prescale counter 2
      wr(A_PR, 32'd3);
      zero_counters();
      run_for(10);
      expect_reg(A_TC, 32'd2, "R2");
      expect_reg(A_PC, 32'd2, "R2");
      // R2: prescale of 0 steps every edge
      wr(A_PR, 32'd0);
      run_for(5);
      expect_reg(A_TC, 32'd7, "R2");
      expect_reg(A_PC, 32'd0, "R2");
      // R2: prescale counter above the limit wraps at once
      wr(A_TC, 32'd0);
      wr(A_PC, 32'd10);
      wr(A_PR, 32'd2);
      run_for(1);
      expect_reg(A_TC, 32'd1, "R2");
      expect_reg(A_PC, 32'd0, "R2");

      // R5, R6, R8: match 1 at 4 with flag and wrap, prescale 0
      for (int i = 0; i < N; i++) wr(AW'(8 + i), 32'hFFFF_FFFF);
      wr(AW'(9), 32'd4);
      wr(A_ACT, 32'h18);
      wr(A_PR, 32'd0);
      zero_counters();
      wr(A_CTRL, 32'd1);
      for (int j = 1; j <= 4; j++) expect_pins('0, 1'b0, "R5");
      expect_pins(7'h02, 1'b0, "R5");
      expect_pins('0, 1'b1, "R6");
      for (int j = 7; j <= 9; j++) expect_pins('0, 1'b1, "R8");
      expect_pins(7'h02, 1'b1, "R8");
      wr(A_CTRL, 32'd0);
      expect_reg(A_TC, 32'd1, "R8");
      expect_reg(A_IRQ, 32'h02, "R6");

      // R5, R11: prescale 2, match 3 at 2 with no actions
      wr(AW'(11), 32'd2);
      wr(A_PR, 32'd2);
      zero_counters();
      wr(A_CTRL, 32'd1);
      for (int j = 1; j <= 8; j++) expect_pins('0, 1'b1, "R5");
      expect_pins(7'h08, 1'b1, "R11");
      expect_pins('0, 1'b1, "R5");
      wr(A_CTRL, 32'd0);
      expect_reg(A_TC, 32'd3, "R11");
      expect_reg(A_PC, 32'd2, "R2");
      expect_reg(A_IRQ, 32'h02, "R11");

      // R7: write-one-to-clear
      wr(A_IRQ, 32'h00);
      expect_reg(A_IRQ, 32'h02, "R7");
      wr(A_IRQ, 32'h02);
      expect_reg(A_IRQ, 32'h00, "R7");
      expect_pins('0, 1'b0, "R7");

      // R7, R9: match 0 at 3 with flag and halt, clear on the event edge
      wr(AW'(8), 32'd3);
      wr(A_ACT, 32'h05);
      wr(A_PR, 32'd0);
      zero_counters();
      wr(A_CTRL, 32'd1);
      repeat (3) @(negedge clk);
      wr(A_IRQ, 32'h01);
      expect_reg(A_IRQ, 32'h01, "R7");
      expect_pins('0, 1'b1, "R7");
      expect_reg(A_CTRL, 32'd0, "R9");
      expect_reg(A_TC, 32'd3, "R9");
      expect_reg(A_PC, 32'd0, "R9");
      wr(A_IRQ, 32'h01);
      expect_reg(A_IRQ, 32'h00, "R7");

      // R9: halt together with wrap on match 2 at 6, prescale 1
      wr(AW'(10), 32'd6);
      wr(A_ACT, 32'h180);
      wr(A_PR, 32'd1);
      zero_counters();
      wr(A_CTRL, 32'd1);
      repeat (20) @(negedge clk);
      expect_reg(A_CTRL, 32'd0, "R9");
      expect_reg(A_TC, 32'd0, "R9");
      expect_reg(A_PC, 32'd0, "R9");
      expect_reg(A_IRQ, 32'd0, "R9");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog (run incomplete): actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule